// File: doc/BRIEF.md
# Control-Flow Coalescing Block Scheduler

This block sits beside a dataflow execution fabric and decides which basic block of a kernel runs next. For every basic block it keeps a bitmap of the threads that still need that block. Each thread that finishes a block reports a (thread id, next block id) pair, and the scheduler sets that thread's bit in the target block's bitmap. Threads are therefore grouped by their next block, whatever path brought them there. A divergent kernel never runs a partly masked group.

When no thread is in flight, the scheduler picks the lowest-numbered block whose bitmap is nonempty. It moves the whole bitmap into a batch register and clears the bitmap. It announces the block id and then issues every waiting thread id, one per cycle, over a valid/ready handshake. An in-flight counter rises with each issued id and falls with each report, and no new block is chosen until it returns to zero. A launch pulse starts a kernel with every thread waiting on block 0. The done output is high while the scheduler is idle, that is, when all bitmaps are empty and nothing is in flight.

The controller has four states. IDLE waits for launch and moves to PICK. PICK waits for a zero in-flight count, then goes to STREAM if some bitmap is nonempty, or back to IDLE if none is. STREAM issues the batch and goes to DRAIN on the handshake of the last id. DRAIN waits for the in-flight count to reach zero and then returns to PICK.

Top module: `cfc_sched`

## Requirements
- R1: A launch pulse in IDLE fills block 0's bitmap with every thread id (0 to NUM_THREADS-1), so the first selected block is 0 with all threads in its batch.
- R2: A report with rep_valid high and rep_blk below NUM_BLOCKS sets bit rep_tid in bitmap rep_blk, and that thread is issued in a later pass of that block.
- R3: A report whose rep_blk equals NUM_BLOCKS (8 by default) retires the thread: it joins no bitmap, yet it still lowers the in-flight count.
- R4: A block is selected only when the in-flight count is zero, and the selected block is always the lowest-numbered one with a nonempty bitmap. Selection is shown by sel_valid, a one-cycle pulse, with sel_blk set, in the first cycle of STREAM.
- R5: The selected bitmap is issued as one batch. Each of its threads appears exactly once on iss_tid, in ascending id order, one per cycle in which iss_valid and iss_ready are both high, with iss_blk equal to the selected block.
- R6: While iss_valid is high and iss_ready is low, iss_valid stays high and iss_tid keeps its value.
- R7: A report that targets the block currently being issued goes into that block's bitmap for a later pass and is never added to the batch in progress.
- R8: The in-flight count rises by one for each issue handshake and falls by one for each report, and it never exceeds NUM_THREADS.
- R9: done is high out of reset and whenever all bitmaps are empty with nothing in flight. It goes low on the cycle after launch and stays low until the kernel has drained.
- R10: In a divergent case, thread classes by id modulo 8 follow these block paths: {0,2,7} take 0,1,5; {1,6} take 0,2,3,5; {3,4,5} take 0,2,4,5. Blocks 0 to 5 are then each scheduled exactly once, in ascending order, and block 5 receives all 64 threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Kernel start pulse, honoured in IDLE |
| rep_valid | input | 1 | Next-block report is present this cycle |
| rep_tid | input | TID_W | Reporting thread id |
| rep_blk | input | BLK_W | Next block id; NUM_BLOCKS means the thread exits |
| sel_valid | output | 1 | One-cycle pulse when a block has been selected |
| sel_blk | output | BLK_W | Id of the selected block |
| iss_valid | output | 1 | A thread id is offered for issue |
| iss_ready | input | 1 | The fabric accepts the offered thread id |
| iss_tid | output | TID_W | Thread id being issued |
| iss_blk | output | BLK_W | Block the issued thread will execute |
| done | output | 1 | Idle: all bitmaps empty and nothing in flight |

## Verification
The checker tests four properties on every cycle: the issue offer holds under back-pressure, selection happens only at a zero in-flight count, the selection pulse lasts one cycle, and the in-flight count stays bounded, moves by one per handshake and is zero whenever done is high. Other behaviours depend on the history of reports, and only the bench scenarios show them. These are the lowest-nonempty choice, the exact set and order of the threads in each batch, the exclusion of a self-targeting report from the batch in progress, retirement, and the final schedule order. The bench keeps its own model of the bitmaps, fed by the reports it sends, and compares every selection and every issued id against that model.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_STREAM,
        ST_DRAIN
    } sched_state_t;

endpackage

// File: rtl/cfc_lowest.sv
// Finds the lowest-indexed set bit of a request vector.
module cfc_lowest #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfc_vectors.sv
// One pending-thread bitmap per basic block.
module cfc_vectors #(
    parameter int NUM_THREADS = 64,
    parameter int NUM_BLOCKS  = 8,
    parameter int TID_W       = 6,
    parameter int BLK_W       = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   fill_entry,
    input  logic                                   set_en,
    input  logic [TID_W-1:0]                       set_tid,
    input  logic [BLK_W-1:0]                       set_blk,
    input  logic                                   take_en,
    input  logic [BLK_W-1:0]                       take_blk,
    output logic [NUM_BLOCKS-1:0][NUM_THREADS-1:0] vec,
    output logic [NUM_BLOCKS-1:0]                  nonempty
);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic [NUM_THREADS-1:0] bits_q;
        logic [NUM_THREADS-1:0] bits_d;

        always_comb begin
            bits_d = bits_q;
            if (take_en && take_blk == BLK_W'(b)) begin
                bits_d = '0;
            end
            if (set_en && set_blk == BLK_W'(b)) begin
                bits_d[set_tid] = 1'b1;
            end
            if (fill_entry && b == 0) begin
                bits_d = '1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else begin
                bits_q <= bits_d;
            end
        end

        assign vec[b]      = bits_q;
        assign nonempty[b] = |bits_q;
    end

endmodule

// File: rtl/cfc_inflight.sv
// Counts thread ids issued but not yet reported back.
module cfc_inflight #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + CNT_W'(1);
        end else if (dec && !inc && count != '0) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cfc_sched.sv
module cfc_sched
    import cfc_pkg::*;
#(
    parameter int NUM_THREADS = 64,
    parameter int NUM_BLOCKS  = 8,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int BLK_W       = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             rep_valid,
    input  logic [TID_W-1:0] rep_tid,
    input  logic [BLK_W-1:0] rep_blk,
    output logic             sel_valid,
    output logic [BLK_W-1:0] sel_blk,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [TID_W-1:0] iss_tid,
    output logic [BLK_W-1:0] iss_blk,
    output logic             done
);

    localparam int CNT_W  = $clog2(NUM_THREADS + 1);
    localparam int BIDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    sched_state_t state_q, state_d;

    logic [NUM_BLOCKS-1:0][NUM_THREADS-1:0] vec;
    logic [NUM_BLOCKS-1:0]                  nonempty;
    logic [NUM_THREADS-1:0]                 batch_q;
    logic [NUM_THREADS-1:0]                 thr_onehot;
    logic [BLK_W-1:0]                       cur_blk_q;
    logic                                   sel_pulse_q;
    logic [CNT_W-1:0]                       inflight;
    logic                                   blk_found;
    logic [BIDX_W-1:0]                      blk_idx;
    logic                                   thr_found;
    logic [TID_W-1:0]                       thr_idx;
    logic                                   fill_entry;
    logic                                   set_en;
    logic                                   pick_go;
    logic                                   iss_fire;
    logic                                   batch_last;
    logic                                   drained;

    assign drained    = (inflight == '0);
    assign fill_entry = launch && (state_q == ST_IDLE);
    assign set_en     = rep_valid && (rep_blk < BLK_W'(NUM_BLOCKS));
    assign pick_go    = (state_q == ST_PICK) && drained && blk_found;
    assign iss_fire   = iss_valid && iss_ready;
    assign thr_onehot = {{(NUM_THREADS - 1){1'b0}}, 1'b1} << thr_idx;
    assign batch_last = ((batch_q & ~thr_onehot) == '0);

    cfc_vectors #(
        .NUM_THREADS(NUM_THREADS),
        .NUM_BLOCKS (NUM_BLOCKS),
        .TID_W      (TID_W),
        .BLK_W      (BLK_W)
    ) u_vectors (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_entry(fill_entry),
        .set_en    (set_en),
        .set_tid   (rep_tid),
        .set_blk   (rep_blk),
        .take_en   (pick_go),
        .take_blk  (BLK_W'(blk_idx)),
        .vec       (vec),
        .nonempty  (nonempty)
    );

    cfc_lowest #(
        .W    (NUM_BLOCKS),
        .IDX_W(BIDX_W)
    ) u_blk_pick (
        .req  (nonempty),
        .found(blk_found),
        .idx  (blk_idx)
    );

    cfc_lowest #(
        .W    (NUM_THREADS),
        .IDX_W(TID_W)
    ) u_thr_pick (
        .req  (batch_q),
        .found(thr_found),
        .idx  (thr_idx)
    );

    cfc_inflight #(
        .CNT_W(CNT_W)
    ) u_inflight (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (iss_fire),
        .dec  (rep_valid),
        .count(inflight)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_PICK;
            ST_PICK: begin
                if (drained) begin
                    state_d = blk_found ? ST_STREAM : ST_IDLE;
                end
            end
            ST_STREAM: if (iss_fire && batch_last) state_d = ST_DRAIN;
            ST_DRAIN:  if (drained) state_d = ST_PICK;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Batch and selected-block registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batch_q     <= '0;
            cur_blk_q   <= '0;
            sel_pulse_q <= 1'b0;
        end else begin
            sel_pulse_q <= pick_go;
            if (pick_go) begin
                batch_q   <= vec[blk_idx];
                cur_blk_q <= BLK_W'(blk_idx);
            end else if (iss_fire) begin
                batch_q <= batch_q & ~thr_onehot;
            end
        end
    end

    // Outputs
    always_comb begin
        iss_valid = (state_q == ST_STREAM) && thr_found;
        iss_tid   = thr_idx;
        iss_blk   = cur_blk_q;
        sel_valid = sel_pulse_q;
        sel_blk   = cur_blk_q;
        done      = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/cfc_sched_chk.sv
module cfc_sched_chk #(
    parameter int NUM_THREADS = 64,
    parameter int TID_W       = 6,
    parameter int CNT_W       = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rep_valid,
    input logic             sel_valid,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [TID_W-1:0] iss_tid,
    input logic             done,
    input logic [CNT_W-1:0] inflight
);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_tid)));

    assert_sel_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (inflight == '0));

    assert_sel_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(NUM_THREADS));

    assert_count_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !rep_valid) |=> (inflight == $past(inflight) + CNT_W'(1)));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (inflight == '0 && !iss_valid));

endmodule

bind cfc_sched cfc_sched_chk #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W),
    .CNT_W      ($clog2(NUM_THREADS + 1))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rep_valid(rep_valid),
    .sel_valid(sel_valid),
    .iss_valid(iss_valid),
    .iss_ready(iss_ready),
    .iss_tid  (iss_tid),
    .done     (done),
    .inflight (inflight)
);

// File: tb/cfc_sched_tb.sv
module cfc_sched_tb;

    localparam int NT = 64;
    localparam int NB = 8;
    localparam int TW = 6;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch = 1'b0;
    logic          rep_valid = 1'b0;
    logic [TW-1:0] rep_tid = '0;
    logic [BW-1:0] rep_blk = '0;
    logic          sel_valid;
    logic [BW-1:0] sel_blk;
    logic          iss_valid;
    logic          iss_ready = 1'b0;
    logic [TW-1:0] iss_tid;
    logic [BW-1:0] iss_blk;
    logic          done;

    always #2 clk = ~clk;

    cfc_sched u_dut (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .rep_valid(rep_valid), .rep_tid(rep_tid), .rep_blk(rep_blk),
        .sel_valid(sel_valid), .sel_blk(sel_blk),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_tid(iss_tid), .iss_blk(iss_blk), .done(done)
    );

    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    int  scen = 0;
    bit  running = 0;
    bit  want_launch = 0;
    bit  mvec [NB][NT];
    bit  exp_batch [NT];
    int  inflight_m = 0;
    int  batch_left = 0;
    int  cur_blk = -1;
    int  last_tid = -1;
    int  iter [NT];
    int  fq_tid [$];
    int  fq_blk [$];
    int  fq_cyc [$];
    int  order [$];
    int  blk_count [NB];
    bit  held = 0;
    int  held_tid = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_block(input int tid, input int blk);
        int c;
        c = tid % 8;
        if (scen == 0) begin
            case (blk)
                0: return (c == 0 || c == 2 || c == 7) ? 1 : 2;
                1: return 5;
                2: return (c == 1 || c == 6) ? 3 : 4;
                3: return 5;
                4: return 5;
                default: return NB;
            endcase
        end else begin
            if (blk == 0) return (tid % 5 == 0) ? NB : 3;
            if (blk == 3) begin
                if (iter[tid] < tid % 4) begin
                    iter[tid]++;
                    return 3;
                end
                return 7;
            end
            return NB;
        end
    endfunction

    task automatic step();
        int lb;
        int cnt;
        bit rdy;
        cyc++;
        // effects of inputs applied at the last edge
        if (launch) begin
            for (int t = 0; t < NT; t++) mvec[0][t] = 1'b1;
        end
        if (rep_valid) begin
            if (int'(rep_blk) < NB) mvec[rep_blk][rep_tid] = 1'b1;
            inflight_m--;
        end
        // selection
        if (sel_valid) begin
            lb = -1;
            for (int b = NB - 1; b >= 0; b--) begin
                for (int t = 0; t < NT; t++) if (mvec[b][t]) lb = b;
            end
            check(inflight_m == 0, "R4", "in flight at selection", inflight_m, 0);
            check(int'(sel_blk) == lb, "R4 R2", "selected block", int'(sel_blk), lb);
            check(batch_left == 0, "R5", "previous batch unfinished", batch_left, 0);
            cnt = 0;
            for (int t = 0; t < NT; t++) begin
                exp_batch[t] = mvec[sel_blk][t];
                if (mvec[sel_blk][t]) cnt++;
                mvec[sel_blk][t] = 1'b0;
            end
            batch_left = cnt;
            cur_blk = int'(sel_blk);
            last_tid = -1;
            order.push_back(cur_blk);
            if (cur_blk >= 0 && cur_blk < NB) blk_count[cur_blk] += cnt;
        end
        if (done) begin
            cnt = 0;
            for (int b = 0; b < NB; b++)
                for (int t = 0; t < NT; t++) if (mvec[b][t]) cnt++;
            check(cnt == 0 && inflight_m == 0 && batch_left == 0, "R9",
                  "done with pending work", cnt + inflight_m + batch_left, 0);
        end
        // issue
        rdy = (scen == 0) ? 1'b1 : ((cyc % 3) != 1);
        if (iss_valid) begin
            if (held) check(int'(iss_tid) == held_tid, "R6", "tid changed under stall",
                            int'(iss_tid), held_tid);
            check(int'(iss_blk) == cur_blk, "R5", "iss_blk", int'(iss_blk), cur_blk);
            check(exp_batch[iss_tid] == 1'b1, "R5 R7", "tid not in batch", int'(iss_tid), -1);
            check(int'(iss_tid) > last_tid, "R5", "tid order", int'(iss_tid), last_tid + 1);
            if (rdy) begin
                exp_batch[iss_tid] = 1'b0;
                batch_left--;
                last_tid = int'(iss_tid);
                inflight_m++;
                fq_tid.push_back(int'(iss_tid));
                fq_blk.push_back(cur_blk);
                fq_cyc.push_back(cyc);
                held = 0;
            end else begin
                held = 1;
                held_tid = int'(iss_tid);
            end
        end else begin
            if (held) check(1'b0, "R6", "valid dropped under stall", 0, 1);
            held = 0;
        end
        iss_ready = rdy;
        // reports
        rep_valid = 1'b0;
        if (fq_tid.size() > 0 && (cyc - fq_cyc[0]) >= 2 && (scen == 0 || (cyc % 2) == 0)) begin
            int t;
            int b;
            t = fq_tid.pop_front();
            b = fq_blk.pop_front();
            void'(fq_cyc.pop_front());
            rep_valid = 1'b1;
            rep_tid = TW'(t);
            rep_blk = BW'(next_block(t, b));
        end
        launch = want_launch;
        want_launch = 0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (running) step();
        end
    end

    task automatic run_kernel(input int s);
        scen = s;
        order.delete();
        for (int b = 0; b < NB; b++) blk_count[b] = 0;
        for (int t = 0; t < NT; t++) iter[t] = 0;
        want_launch = 1;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9", "done low after launch", int'(done), 0);
        while (!(done && inflight_m == 0 && fq_tid.size() == 0)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R9", "done after reset", int'(done), 1);
        check(iss_valid == 1'b0, "R5", "iss_valid after reset", int'(iss_valid), 0);
        check(sel_valid == 1'b0, "R4", "sel_valid after reset", int'(sel_valid), 0);
        running = 1;

        // divergent reference case
        run_kernel(0);
        check(order.size() == 6, "R10", "scheduled block count", order.size(), 6);
        for (int i = 0; i < 6; i++) begin
            if (i < order.size())
                check(order[i] == i, "R10", "schedule order", order[i], i);
        end
        check(blk_count[0] == NT, "R1", "entry batch size", blk_count[0], NT);
        check(blk_count[5] == NT, "R10", "join block batch size", blk_count[5], NT);
        check(blk_count[1] + blk_count[2] == NT, "R2", "split sizes", blk_count[1] + blk_count[2], NT);

        // loop and exit case
        run_kernel(1);
        begin
            int exp_order [6] = '{0, 3, 3, 3, 3, 7};
            int exp3;
            int live;
            exp3 = 0;
            live = 0;
            for (int t = 0; t < NT; t++) begin
                if (t % 5 != 0) begin
                    exp3 += t % 4 + 1;
                    live++;
                end
            end
            check(order.size() == 6, "R7", "loop schedule length", order.size(), 6);
            for (int i = 0; i < 6; i++) begin
                if (i < order.size())
                    check(order[i] == exp_order[i], "R7", "loop schedule order", order[i], exp_order[i]);
            end
            check(blk_count[3] == exp3, "R7", "loop block issues", blk_count[3], exp3);
            check(blk_count[7] == live, "R3", "threads past exit", blk_count[7], live);
        end
        check(done == 1'b1, "R3 R9", "done at end", int'(done), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule